// File: doc/BRIEF.md
# Stack and Status Sequencer

This block carries out the stack side of the eight stack-touching commands of a small 8-bit processor: subroutine call and return, software break and return from interrupt, and push or pull of the accumulator and the status byte. When it is idle, a start pulse captures the command together with the stack pointer, program counter, status byte, accumulator, call target and interrupt vector. The block then performs one stack memory access per cycle. When the command finishes, it presents the updated stack pointer, program counter, status byte and accumulator and raises `done_o` for one cycle.

The stack occupies memory page 0x01. A push writes at the current pointer and then decrements it. A pull increments the pointer and then reads. The pointer wraps modulo 256 in both directions. The stack memory is synchronous: the read data for a request appears on `mem_rdata_i` in the cycle after `mem_re_o`. The status byte holds N, V, U (always-one), B (break), D, I, Z, C from bit 7 down to bit 0.

Top module: `stk_seq`

## Requirements
- R1: Every access goes to address {0x01, pointer}. A push writes at SP and leaves SP-1. A pull reads at SP+1 and leaves SP+1. Both wrap modulo 256.
- R2: Call (command 0) writes the high byte of PC+2 and then its low byte, and sets PC to `target_i`.
- R3: Return from subroutine (command 1) reads the low byte and then the high byte, and sets PC to that value plus 1, with a 16-bit wrap.
- R4: Break (command 2) writes the high byte of PC+2, then its low byte, then the status byte with B (bit 4) set. The live status gains I (bit 2), and PC becomes `vec_i`.
- R5: Return from interrupt (command 3) reads the status byte, then the PC low byte, then the PC high byte, and applies no increment. The loaded status has U (bit 5) forced to 1 and its other bits kept as read.
- R6: Push status (command 5) writes the status byte with B set. The live status is unchanged.
- R7: Pull status (command 7) loads the byte read with U forced to 1 and B forced to 0.
- R8: Push accumulator (command 4) writes the accumulator and changes no flag. Pull accumulator (command 6) loads the accumulator, sets N to bit 7 of the value and Z to (value==0), and keeps every other flag.
- R9: After reset the status output is 0x24, the pointer, PC and accumulator outputs are 0, and no access, busy or done is signalled.
- R10: A command with n stack accesses raises `done_o` for exactly one cycle, n+1 cycles after the edge that accepted it. The outputs hold their final values at that point.
- R11: A start pulse raised while a command is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a command (accepted only while idle) |
| cmd_i | input | 3 | Command code |
| sp_i | input | 8 | Stack pointer at start |
| pc_i | input | 16 | Program counter of the current instruction |
| flags_i | input | 8 | Live status byte |
| acc_i | input | 8 | Accumulator |
| target_i | input | 16 | Call destination |
| vec_i | input | 16 | Break vector contents |
| mem_rdata_i | input | 8 | Stack read data, one cycle after the request |
| mem_we_o | output | 1 | Stack write request |
| mem_re_o | output | 1 | Stack read request |
| mem_addr_o | output | 16 | Stack address |
| mem_wdata_o | output | 8 | Stack write data |
| sp_o | output | 8 | Updated stack pointer |
| pc_o | output | 16 | Updated program counter |
| flags_o | output | 8 | Updated status byte |
| acc_o | output | 8 | Updated accumulator |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong working pointer shows at the ports within a cycle: the next request carries a misplaced address, and the bench memory records the stray byte or returns the wrong one. A byte-order or forcing fault stays hidden until the completion cycle, when `pc_o` or `flags_o` differs from the value the bench computed, or until the bench inspects the written bytes. A misplaced pipeline stage in the read path shifts the pulse away from the expected n+1 cycles and also corrupts the returned address.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    CMD_CALL  = 3'd0,
    CMD_RET   = 3'd1,
    CMD_BRK   = 3'd2,
    CMD_IRET  = 3'd3,
    CMD_PUSHA = 3'd4,
    CMD_PUSHF = 3'd5,
    CMD_PULLA = 3'd6,
    CMD_PULLF = 3'd7
  } cmd_e;

  localparam int FL_N = 7;
  localparam int FL_V = 6;
  localparam int FL_U = 5;
  localparam int FL_B = 4;
  localparam int FL_D = 3;
  localparam int FL_I = 2;
  localparam int FL_Z = 1;
  localparam int FL_C = 0;
  localparam logic [7:0] FLAGS_RST = 8'h24;

  function automatic logic [1:0] last_step(cmd_e c);
    case (c)
      CMD_CALL, CMD_RET: return 2'd1;
      CMD_BRK, CMD_IRET: return 2'd2;
      default:           return 2'd0;
    endcase
  endfunction

  function automatic logic is_pull(cmd_e c);
    return (c == CMD_RET) || (c == CMD_IRET) || (c == CMD_PULLA) || (c == CMD_PULLF);
  endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int SP_W = 8,
  parameter int AW   = 16,
  parameter logic [AW-SP_W-1:0] PAGE = 'h01
) (
  input  logic [SP_W-1:0] sp_i,
  input  logic            pull_i,
  output logic [AW-1:0]   addr_o,
  output logic [SP_W-1:0] sp_next_o
);
  logic [SP_W-1:0] sp_inc;

  assign sp_inc    = sp_i + 1'b1;
  // pre-increment on pull, post-decrement on push
  assign addr_o    = {PAGE, (pull_i ? sp_inc : sp_i)};
  assign sp_next_o = pull_i ? sp_inc : sp_i - 1'b1;
endmodule

// File: rtl/stk_flag_fix.sv
module stk_flag_fix
  import stk_pkg::*;
(
  input  cmd_e       cmd_i,
  input  logic [7:0] live_i,
  input  logic [7:0] pulled_i,
  output logic [7:0] push_stat_o,
  output logic [7:0] flags_o
);
  always_comb begin
    push_stat_o       = live_i;
    push_stat_o[FL_B] = 1'b1;
    flags_o           = live_i;
    case (cmd_i)
      CMD_BRK:  flags_o[FL_I] = 1'b1;
      CMD_IRET: begin
        flags_o       = pulled_i;
        flags_o[FL_U] = 1'b1;
      end
      CMD_PULLA: begin
        flags_o[FL_N] = pulled_i[7];
        flags_o[FL_Z] = (pulled_i == 8'h00);
      end
      CMD_PULLF: begin
        flags_o       = pulled_i;
        flags_o[FL_U] = 1'b1;
        flags_o[FL_B] = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int SP_W = 8,
  parameter int AW   = 16,
  parameter logic [AW-SP_W-1:0] PAGE = 'h01
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      cmd_i,
  input  logic [SP_W-1:0] sp_i,
  input  logic [AW-1:0]   pc_i,
  input  logic [7:0]      flags_i,
  input  logic [7:0]      acc_i,
  input  logic [AW-1:0]   target_i,
  input  logic [AW-1:0]   vec_i,
  input  logic [7:0]      mem_rdata_i,
  output logic            mem_we_o,
  output logic            mem_re_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  output logic [SP_W-1:0] sp_o,
  output logic [AW-1:0]   pc_o,
  output logic [7:0]      flags_o,
  output logic [7:0]      acc_o,
  output logic            busy_o,
  output logic            done_o
);
  localparam int NBUF = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_FIN} st_e;

  st_e             st_q;
  cmd_e            cmd_q;
  logic [1:0]      step_q;
  logic [SP_W-1:0] sp_q;
  logic [AW-1:0]   pc_q, tgt_q, vec_q;
  logic [7:0]      flags_q, acc_q;
  logic [7:0]      rbuf_q [NBUF];
  logic            pend_q;
  logic [1:0]      pend_idx_q;
  logic            done_q;

  logic            pull;
  logic [SP_W-1:0] sp_next;
  logic [AW-1:0]   ret_pc;
  logic [7:0]      byte_v [NBUF];
  logic [7:0]      push_stat, flags_next;
  logic [AW-1:0]   pc_next;

  assign pull   = is_pull(cmd_q);
  assign ret_pc = pc_q + AW'(2);

  stk_ptr #(.SP_W(SP_W), .AW(AW), .PAGE(PAGE)) u_ptr (
    .sp_i      (sp_q),
    .pull_i    (pull),
    .addr_o    (mem_addr_o),
    .sp_next_o (sp_next)
  );

  // last read byte is still on the bus during the finish cycle
  always_comb begin
    for (int i = 0; i < NBUF; i++)
      byte_v[i] = (pend_q && (pend_idx_q == 2'(i))) ? mem_rdata_i : rbuf_q[i];
  end

  stk_flag_fix u_fix (
    .cmd_i       (cmd_q),
    .live_i      (flags_q),
    .pulled_i    (byte_v[0]),
    .push_stat_o (push_stat),
    .flags_o     (flags_next)
  );

  assign mem_we_o = (st_q == ST_ACC) && !pull;
  assign mem_re_o = (st_q == ST_ACC) && pull;

  always_comb begin
    mem_wdata_o = 8'h00;
    case (cmd_q)
      CMD_CALL, CMD_BRK:
        case (step_q)
          2'd0:    mem_wdata_o = ret_pc[AW-1 -: 8];
          2'd1:    mem_wdata_o = ret_pc[7:0];
          default: mem_wdata_o = push_stat;
        endcase
      CMD_PUSHA: mem_wdata_o = acc_q;
      CMD_PUSHF: mem_wdata_o = push_stat;
      default: ;
    endcase
  end

  always_comb begin
    pc_next = pc_q;
    case (cmd_q)
      CMD_CALL: pc_next = tgt_q;
      CMD_BRK:  pc_next = vec_q;
      CMD_RET:  pc_next = AW'({byte_v[1], byte_v[0]}) + AW'(1);
      CMD_IRET: pc_next = AW'({byte_v[2], byte_v[1]});
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cmd_q      <= CMD_CALL;
      step_q     <= '0;
      sp_q       <= '0;
      pc_q       <= '0;
      tgt_q      <= '0;
      vec_q      <= '0;
      flags_q    <= FLAGS_RST;
      acc_q      <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
      done_q     <= 1'b0;
      for (int i = 0; i < NBUF; i++) rbuf_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (pend_q) rbuf_q[pend_idx_q] <= mem_rdata_i;
      case (st_q)
        ST_IDLE: begin
          pend_q <= 1'b0;
          if (start_i) begin
            cmd_q   <= cmd_e'(cmd_i);
            sp_q    <= sp_i;
            pc_q    <= pc_i;
            flags_q <= flags_i;
            acc_q   <= acc_i;
            tgt_q   <= target_i;
            vec_q   <= vec_i;
            step_q  <= '0;
            st_q    <= ST_ACC;
          end
        end
        ST_ACC: begin
          sp_q       <= sp_next;
          pend_q     <= pull;
          pend_idx_q <= step_q;
          if (step_q == last_step(cmd_q)) st_q <= ST_FIN;
          else                             step_q <= step_q + 2'd1;
        end
        default: begin
          pend_q  <= 1'b0;
          flags_q <= flags_next;
          pc_q    <= pc_next;
          if (cmd_q == CMD_PULLA) acc_q <= byte_v[0];
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
      endcase
    end
  end

  assign sp_o    = sp_q;
  assign pc_o    = pc_q;
  assign flags_o = flags_q;
  assign acc_o   = acc_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;

  AST_STACK_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || mem_re_o) |-> (mem_addr_o[AW-1:SP_W] == PAGE)); // R1
  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (sp_o == $past(mem_addr_o[SP_W-1:0]) - 1'b1)); // R1
  AST_PULL_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> (sp_o == $past(mem_addr_o[SP_W-1:0]))); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_BRK_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_q == CMD_BRK) |-> (flags_o[FL_I] && pc_o == vec_q)); // R4
  AST_IRET_U: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_q == CMD_IRET) |-> flags_o[FL_U]); // R5
  AST_PULLF_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_q == CMD_PULLF) |-> (flags_o[FL_U] && !flags_o[FL_B])); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_we_o || mem_re_o)); // R11
endmodule

// File: tb/sim_stk_seq.sv
module sim_stk_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TGT = 16'h4567;
  localparam logic [15:0] VEC = 16'h8000;

  typedef struct packed {
    logic [2:0]  cmd;
    logic [7:0]  sp;
    logic [15:0] pc;
    logic [7:0]  fl;
    logic [7:0]  acc;
    logic [7:0]  p0, p1, p2;
    logic [7:0]  xsp;
    logic [15:0] xpc;
    logic [7:0]  xfl;
    logic [7:0]  xacc;
    logic [7:0]  w0, w1, w2;
    logic [1:0]  nw;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{3'd0, 8'hFF, 16'h20FE, 8'h24, 8'h11, 8'h00, 8'h00, 8'h00, 8'hFD, 16'h4567, 8'h24, 8'h11, 8'h21, 8'h00, 8'h00, 2'd2},
    '{3'd0, 8'h00, 16'h1000, 8'h24, 8'h11, 8'h00, 8'h00, 8'h00, 8'hFE, 16'h4567, 8'h24, 8'h11, 8'h10, 8'h02, 8'h00, 2'd2},
    '{3'd1, 8'hFD, 16'h5555, 8'h24, 8'h11, 8'h34, 8'h12, 8'h00, 8'hFF, 16'h1235, 8'h24, 8'h11, 8'h00, 8'h00, 8'h00, 2'd0},
    '{3'd1, 8'h10, 16'h5555, 8'hA5, 8'h11, 8'hFF, 8'h12, 8'h00, 8'h12, 16'h1300, 8'hA5, 8'h11, 8'h00, 8'h00, 8'h00, 2'd0},
    '{3'd1, 8'hFE, 16'h5555, 8'h24, 8'h11, 8'hFF, 8'hFF, 8'h00, 8'h00, 16'h0000, 8'h24, 8'h11, 8'h00, 8'h00, 8'h00, 2'd0},
    '{3'd2, 8'hFF, 16'h3000, 8'h21, 8'h11, 8'h00, 8'h00, 8'h00, 8'hFC, 16'h8000, 8'h25, 8'h11, 8'h30, 8'h02, 8'h31, 2'd3},
    '{3'd3, 8'hFC, 16'h5555, 8'h24, 8'h11, 8'hC3, 8'h02, 8'h30, 8'hFF, 16'h3002, 8'hE3, 8'h11, 8'h00, 8'h00, 8'h00, 2'd0},
    '{3'd4, 8'h80, 16'h5555, 8'h24, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h7F, 16'h5555, 8'h24, 8'h5A, 8'h5A, 8'h00, 8'h00, 2'd1},
    '{3'd5, 8'h40, 16'h5555, 8'hA5, 8'h11, 8'h00, 8'h00, 8'h00, 8'h3F, 16'h5555, 8'hA5, 8'h11, 8'hB5, 8'h00, 8'h00, 2'd1},
    '{3'd6, 8'h7F, 16'h5555, 8'h27, 8'h11, 8'h80, 8'h00, 8'h00, 8'h80, 16'h5555, 8'hA5, 8'h80, 8'h00, 8'h00, 8'h00, 2'd0},
    '{3'd6, 8'hFF, 16'h5555, 8'hA4, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00, 16'h5555, 8'h26, 8'h00, 8'h00, 8'h00, 8'h00, 2'd0},
    '{3'd7, 8'h20, 16'h5555, 8'h24, 8'h11, 8'h10, 8'h00, 8'h00, 8'h21, 16'h5555, 8'h20, 8'h11, 8'h00, 8'h00, 8'h00, 2'd0},
    '{3'd7, 8'h21, 16'h5555, 8'h24, 8'h11, 8'hDF, 8'h00, 8'h00, 8'h22, 16'h5555, 8'hEF, 8'h11, 8'h00, 8'h00, 8'h00, 2'd0},
    '{3'd3, 8'h00, 16'h5555, 8'h24, 8'h11, 8'hD0, 8'hFF, 8'h7F, 8'h03, 16'h7FFF, 8'hF0, 8'h11, 8'h00, 8'h00, 8'h00, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cmd = '0;
  logic [7:0]  sp = '0, flags = '0, acc = '0;
  logic [15:0] pc = '0;
  logic [7:0]  rdata_q = '0;
  logic        we, re, busy, done;
  logic [15:0] addr, pc_o;
  logic [7:0]  wdata, sp_o, flags_o, acc_o;

  logic [7:0]  smem [256];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_a = '0, poke_d = '0;
  int          bad_page = 0;
  int          n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .sp_i(sp),
    .pc_i(pc), .flags_i(flags), .acc_i(acc), .target_i(TGT), .vec_i(VEC),
    .mem_rdata_i(rdata_q), .mem_we_o(we), .mem_re_o(re), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .sp_o(sp_o), .pc_o(pc_o), .flags_o(flags_o),
    .acc_o(acc_o), .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    if (poke_en) smem[poke_a] <= poke_d;
    else if (we) smem[addr[7:0]] <= wdata;
    if (re) rdata_q <= smem[addr[7:0]];
    if ((we || re) && addr[15:8] != 8'h01) bad_page <= bad_page + 1;
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd5: return "R6";
      3'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic int n_acc(input logic [2:0] c);
    case (c)
      3'd0, 3'd1: return 2;
      3'd2, 3'd3: return 3;
      default:    return 1;
    endcase
  endfunction

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic launch(input logic [2:0] c, input logic [7:0] s, input logic [15:0] p,
                        input logic [7:0] f, input logic [7:0] a);
    @(negedge clk);
    cmd = c; sp = s; pc = p; flags = f; acc = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 50) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    int cyc;
    for (int i = 0; i < 256; i++) smem[i] = 8'h00;
    #(CLK_PERIOD*2 + 2);
    // R9: reset state
    chk("R9", "flags", 16'(flags_o), 16'h0024);
    chk("R9", "sp", 16'(sp_o), 16'h0000);
    chk("R9", "pc", pc_o, 16'h0000);
    chk("R9", "acc", 16'(acc_o), 16'h0000);
    chk("R9", "we/re/busy/done", {12'h0, we, re, busy, done}, 16'h0000);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = TBL[v];
      poke(8'(t.sp + 8'd1), t.p0);
      poke(8'(t.sp + 8'd2), t.p1);
      poke(8'(t.sp + 8'd3), t.p2);
      launch(t.cmd, t.sp, t.pc, t.fl, t.acc);
      wait_done(cyc);
      chk("R10", "done latency", 16'(cyc), 16'(n_acc(t.cmd) + 1));
      chk("R1", "sp", 16'(sp_o), 16'(t.xsp));
      chk(tag_of(t.cmd), "pc", pc_o, t.xpc);
      chk(tag_of(t.cmd), "flags", 16'(flags_o), 16'(t.xfl));
      chk(tag_of(t.cmd), "acc", 16'(acc_o), 16'(t.xacc));
      if (t.nw > 0) chk(tag_of(t.cmd), "byte0", 16'(smem[t.sp]), 16'(t.w0));
      if (t.nw > 1) chk(tag_of(t.cmd), "byte1", 16'(smem[8'(t.sp - 8'd1)]), 16'(t.w1));
      if (t.nw > 2) chk(tag_of(t.cmd), "byte2", 16'(smem[8'(t.sp - 8'd2)]), 16'(t.w2));
      @(negedge clk);
      chk("R10", "done single cycle", 16'(done), 16'h0000);
    end

    // R11: start during a call is ignored
    poke(8'h5E, 8'hEE);
    launch(3'd0, 8'h60, 16'h1000, 8'h24, 8'h11);
    cmd = 3'd4; acc = 8'h77; start = 1'b1;
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk("R11", "sp", 16'(sp_o), 16'h005E);
    chk("R11", "pc", pc_o, TGT);
    chk("R11", "acc", 16'(acc_o), 16'h0011);
    chk("R11", "untouched byte", 16'(smem[8'h5E]), 16'h00EE);
    repeat (4) @(negedge clk);
    chk("R11", "no second run", {14'h0, busy, done}, 16'h0000);
    chk("R1", "off-page accesses", 16'(bad_page), 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule